// File: doc/BRIEF.md
# Cascaded Dual-Channel Timer Counter

This block holds two counter channels behind a simple register bus. Each channel counts one clock source, selected per channel: one of four prescaled versions of the bus clock, or an external edge input. In waveform mode a channel drives an output line. Two compare registers set, clear or toggle that line when the count reaches their value.

The block can route channel 0's output line into channel 1's external input. This makes a wide counter with no carry logic between the halves. If channel 0 sets its line at count 1 and clears it at half range, channel 1 advances once per full pass of channel 0. Software reads the live counts in the order upper, lower, upper, and retries when the two upper values differ.

A block-level trigger clears both counters together, and a keyed protection register locks the mode registers.

Top module: `cascade_timer`

## Requirements
- R1: Each channel has a 64-byte window at channel × 0x40. The mode register is at +0x04, the live count at +0x10, compare A at +0x14 and compare C at +0x1C, and all of these read back. The count register ignores writes, and every register resets to 0.
- R2: In a channel's control register at +0x00, writing bit 0 starts the count and writing bit 1 stops it. Bit 1 wins when both are written, and a stopped count holds its value.
- R3: Mode bits 2:0 pick the count source: 0 = bus clock/2, 1 = /8, 2 = /32, 3 = /128, 6 = external input. Any other value stops the count.
- R4: The count runs freely. It goes from all ones to 0, and it does not restart when it matches compare C.
- R5: With mode bit 15 set, the output line is updated on each count step. When the new count equals compare A, action bits 17:16 apply; then, when it equals compare C, action bits 19:18 apply. The action codes are 0 keep, 1 set, 2 clear and 3 toggle. With bit 15 clear the line is low.
- R6: A channel's external input passes through a synchronizer. Each rising edge advances the count exactly once, whatever the pulse width.
- R7: Bits 3:2 of the block register at 0xC4 select channel 1's external input: 0 = pin ext_clk[1], 2 = channel 0's output line, 1 or 3 = none. The field reads back in place.
- R8: With channel 0 set to set-at-1 and clear-at-half-range, and channel 1 counting its external input selected as channel 0's line, channel 1's count equals the number of rising edges on channel 0's line.
- R9: Writing bit 0 at 0xC0 clears both counts, both output lines and the prescaler in the same cycle.
- R10: A write at 0xE4 takes effect only when bits 31:8 hold 0x54494D. Its bit 0 then turns protection on or off, and reads of 0xE4 return that bit. While protection is on, mode register writes are ignored and other registers stay writable.
- R11: irq_enable holds eight bits per channel (channel 1 in the upper byte) and resets to all ones. A write to +0x28 clears the bits where the data has a 1. That address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr | input | 1 | Write strobe, one cycle per write |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| ext_clk | input | 2 | External count inputs, one per channel |
| wave_out | output | 2 | Per-channel waveform lines |
| irq_enable | output | 16 | Per-channel interrupt enable bits |

## Verification
The bench targets three failures of a cascaded counter.
- A lost or doubled chain edge would leave channel 1's count differing from the number of rising edges seen on channel 0's line.
- A count that restarts at compare C would never climb above the compare value.
- A line that applies the wrong action, or A after C, would go high outside its expected window, or stay high when both compares match the same count.

Edge handling is checked with wide pulses, which a level-sensitive counter would count many times. The trigger is checked on a stopped channel, where a design that clears only running counts would keep a stale value. Protection is checked with a wrong key, which a design that ignores the key would accept.

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int CW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [1:0]  ext_clk,
  output logic [1:0]  wave_out,
  output logic [15:0] irq_enable
);

  localparam logic [7:0]  A_TRIG = 8'hC0;
  localparam logic [7:0]  A_BLK  = 8'hC4;
  localparam logic [7:0]  A_LOCK = 8'hE4;
  localparam logic [23:0] KEY    = 24'h54494D;

  logic [31:0]   mode_q [2];
  logic [31:0]   ra_q   [2];
  logic [31:0]   rc_q   [2];
  logic [CW-1:0] cnt_q  [2];
  logic          wave_q [2];
  logic [7:0]    ie_q   [2];
  logic          xin    [2];
  logic          lock_q;
  logic [1:0]    route_q;
  logic [6:0]    presc_q;

  wire trig = wr && addr == A_TRIG && wdata[0];

  function automatic logic apply_act(input logic cur, input logic [1:0] code);
    case (code)
      2'd1:    return 1'b1;
      2'd2:    return 1'b0;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) presc_q <= '0;
    else if (trig) presc_q <= '0;
    else presc_q <= presc_q + 7'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lock_q  <= 1'b0;
      route_q <= 2'd0;
    end else begin
      if (wr && addr == A_LOCK && wdata[31:8] == KEY) lock_q <= wdata[0];
      if (wr && addr == A_BLK) route_q <= wdata[3:2];
    end

  assign xin[0] = ext_clk[0];
  assign xin[1] = (route_q == 2'd0) ? ext_clk[1] :
                  (route_q == 2'd2) ? wave_q[0]  : 1'b0;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    localparam logic [7:0] BASE = 8'(g * 64);
    logic [2:0]    xs_q;
    logic          en_q;
    logic          tick;
    logic          wa;
    logic          wc;
    logic [CW-1:0] nxt;

    wire xrise = xs_q[1] & ~xs_q[2];
    wire adv   = en_q & tick;

    always_comb begin
      case (mode_q[g][2:0])
        3'd0:    tick = presc_q[0];
        3'd1:    tick = &presc_q[2:0];
        3'd2:    tick = &presc_q[4:0];
        3'd3:    tick = &presc_q;
        3'd6:    tick = xrise;
        default: tick = 1'b0;
      endcase
    end

    assign nxt = cnt_q[g] + 1'b1;
    assign wa  = (nxt == ra_q[g][CW-1:0]) ? apply_act(wave_q[g], mode_q[g][17:16]) : wave_q[g];
    assign wc  = (nxt == rc_q[g][CW-1:0]) ? apply_act(wa, mode_q[g][19:18]) : wa;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        mode_q[g] <= '0;
        ra_q[g]   <= '0;
        rc_q[g]   <= '0;
        ie_q[g]   <= '1;
        en_q      <= 1'b0;
        xs_q      <= '0;
      end else begin
        xs_q <= {xs_q[1:0], xin[g]};
        if (wr && addr == BASE) begin
          if (wdata[1]) en_q <= 1'b0;
          else if (wdata[0]) en_q <= 1'b1;
        end
        if (wr && addr == BASE + 8'h04 && !lock_q) mode_q[g] <= wdata;
        if (wr && addr == BASE + 8'h14) ra_q[g] <= wdata;
        if (wr && addr == BASE + 8'h1C) rc_q[g] <= wdata;
        if (wr && addr == BASE + 8'h28) ie_q[g] <= ie_q[g] & ~wdata[7:0];
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt_q[g]  <= '0;
        wave_q[g] <= 1'b0;
      end else if (trig) begin
        cnt_q[g]  <= '0;
        wave_q[g] <= 1'b0;
      end else begin
        if (adv) cnt_q[g] <= nxt;
        if (!mode_q[g][15]) wave_q[g] <= 1'b0;
        else if (adv) wave_q[g] <= wc;
      end

    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_q[g] == $past(cnt_q[g]) || cnt_q[g] == $past(cnt_q[g]) + 1'b1 || cnt_q[g] == '0));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (cnt_q[g] == $past(cnt_q[g]) || cnt_q[g] == '0));

    p_trig_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (cnt_q[g] == '0 && !wave_q[g]));

    p_mode_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && wr && addr == BASE + 8'h04) |=> $stable(mode_q[g]));

    p_line_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[g][15] |=> !wave_q[g]);

    p_ie_fall_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ie_q[g] & ~$past(ie_q[g])) == 8'h00));
  end

  wire ch = addr[6];

  always_comb begin
    rdata = '0;
    if (!addr[7]) begin
      case (addr[5:0])
        6'h04:   rdata = mode_q[ch];
        6'h10:   rdata = 32'(cnt_q[ch]);
        6'h14:   rdata = ra_q[ch];
        6'h1C:   rdata = rc_q[ch];
        default: rdata = '0;
      endcase
    end else if (addr == A_BLK) begin
      rdata = {28'd0, route_q, 2'd0};
    end else if (addr == A_LOCK) begin
      rdata = {31'd0, lock_q};
    end
  end

  assign wave_out   = {wave_q[1], wave_q[0]};
  assign irq_enable = {ie_q[1], ie_q[0]};

endmodule

// File: tb/cascade_timer_tb.sv
module cascade_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ext_clk = '0;
  logic [1:0]  wave_out;
  logic [15:0] irq_enable;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cascade_timer #(.CW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_clk(ext_clk), .wave_out(wave_out), .irq_enable(irq_enable)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input int idx, input int hi, input int lo);
    @(negedge clk);
    ext_clk[idx] = 1'b1;
    repeat (hi) @(negedge clk);
    ext_clk[idx] = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(8'h04, d); check("R1 reset mode0", d, 0);
    rd_reg(8'h54, d); check("R1 reset ra1", d, 0);
    rd_reg(8'h10, d); check("R1 reset cnt0", d, 0);
    rd_reg(8'hE4, d); check("R10 reset lock", d, 0);
    check("R5 reset lines", {30'd0, wave_out}, 0);
    check("R11 reset enables", {16'd0, irq_enable}, 32'hFFFF);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr_reg(8'h54, 32'h0000_0012);
    wr_reg(8'h5C, 32'hDEAD_0034);
    wr_reg(8'h44, 32'h000A_8006);
    rd_reg(8'h54, d); check("R1 ra1 readback", d, 32'h12);
    rd_reg(8'h5C, d); check("R1 rc1 readback", d, 32'hDEAD_0034);
    rd_reg(8'h44, d); check("R1 mode1 readback", d, 32'h000A_8006);
    wr_reg(8'h10, 32'h5);
    rd_reg(8'h10, d); check("R1 count ignores write", d, 0);
    wr_reg(8'h44, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr_reg(8'h28, 32'h05);
    check("R11 ch0 disable bits", {16'd0, irq_enable}, 32'hFFFA);
    wr_reg(8'h68, 32'h80);
    check("R11 ch1 disable bit", {16'd0, irq_enable}, 32'h7FFA);
    rd_reg(8'h28, d); check("R11 reads zero", d, 0);
  endtask

  task automatic t_clock_sel();
    logic [31:0] a, b;
    wr_reg(8'h04, 32'h1);
    wr_reg(8'h00, 32'h1);
    rd_reg(8'h10, a); repeat (79) @(negedge clk); rd_reg(8'h10, b);
    check("R3 div8 steps", (b - a) & 32'hFF, 10);
    wr_reg(8'h04, 32'h0);
    rd_reg(8'h10, a); repeat (39) @(negedge clk); rd_reg(8'h10, b);
    check("R3 div2 steps", (b - a) & 32'hFF, 20);
    wr_reg(8'h04, 32'h2);
    rd_reg(8'h10, a); repeat (319) @(negedge clk); rd_reg(8'h10, b);
    check("R3 div32 steps", (b - a) & 32'hFF, 10);
    wr_reg(8'h04, 32'h7);
    rd_reg(8'h10, a); repeat (39) @(negedge clk); rd_reg(8'h10, b);
    check("R3 code 7 stops", b, a);
    wr_reg(8'h04, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] a, b;
    wr_reg(8'h00, 32'h2);
    rd_reg(8'h10, a); repeat (29) @(negedge clk); rd_reg(8'h10, b);
    check("R2 stopped holds", b, a);
    wr_reg(8'h00, 32'h1);
    wr_reg(8'h00, 32'h3);
    rd_reg(8'h10, a); repeat (29) @(negedge clk); rd_reg(8'h10, b);
    check("R2 stop wins", b, a);
  endtask

  task automatic t_trig();
    logic [31:0] d;
    rd_reg(8'h10, d);
    check("R9 precondition nonzero", {31'd0, d != 0}, 1);
    wr_reg(8'hC0, 32'h1);
    rd_reg(8'h10, d); check("R9 ch0 cleared", d, 0);
    rd_reg(8'h50, d); check("R9 ch1 cleared", d, 0);
    check("R9 lines low", {30'd0, wave_out}, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    logic [7:0] prev;
    int bad = 0;
    bit saw_wrap = 0;
    bit saw_past = 0;
    wr_reg(8'h00, 32'h2);
    wr_reg(8'h04, 32'h0);
    wr_reg(8'h1C, 32'h10);
    wr_reg(8'hC0, 32'h1);
    wr_reg(8'h00, 32'h1);
    prev = 8'h0;
    for (int i = 0; i < 700; i++) begin
      rd_reg(8'h10, d);
      if (d[7:0] != prev) begin
        if (d[7:0] != prev + 8'd1) bad++;
        if (prev == 8'hFF && d[7:0] == 8'h00) saw_wrap = 1;
        if (prev == 8'h10 && d[7:0] == 8'h11) saw_past = 1;
        prev = d[7:0];
      end
    end
    check("R4 single steps", bad, 0);
    check("R4 wraps to zero", {31'd0, saw_wrap}, 1);
    check("R4 no restart at compare C", {31'd0, saw_past}, 1);
  endtask

  task automatic run_line(input logic [31:0] mode, input logic [31:0] ra, input logic [31:0] rc,
                          input int kind, input string tag);
    logic [31:0] d;
    logic [7:0] prev;
    logic exp;
    int bad = 0;
    wr_reg(8'h00, 32'h2);
    wr_reg(8'h04, mode);
    wr_reg(8'h14, ra);
    wr_reg(8'h1C, rc);
    wr_reg(8'hC0, 32'h1);
    wr_reg(8'h00, 32'h1);
    prev = 8'h0;
    exp = 1'b0;
    for (int i = 0; i < 600; i++) begin
      rd_reg(8'h10, d);
      if (kind == 0) exp = (d[7:0] >= ra[7:0]) && (d[7:0] < rc[7:0]);
      else if (kind == 1) begin
        if (d[7:0] != prev && d[7:0] == ra[7:0]) exp = ~exp;
      end else exp = 1'b0;
      prev = d[7:0];
      if (wave_out[0] !== exp) bad++;
    end
    check(tag, bad, 0);
  endtask

  task automatic t_wave();
    run_line(32'h0009_8000, 32'h20, 32'h40, 0, "R5 set at A clear at C");
    run_line(32'h0003_8000, 32'h05, 32'hFF, 1, "R5 toggle at A");
    run_line(32'h0009_0000, 32'h01, 32'h80, 2, "R5 line low without wave bit");
    run_line(32'h0009_8000, 32'h08, 32'h08, 2, "R5 C applied after A");
  endtask

  task automatic t_ext();
    logic [31:0] d;
    wr_reg(8'h00, 32'h2);
    wr_reg(8'h04, 32'h6);
    wr_reg(8'hC0, 32'h1);
    wr_reg(8'h00, 32'h1);
    for (int i = 0; i < 5; i++) pulse(0, 3, 3);
    pulse(0, 20, 4);
    pulse(0, 2, 6);
    rd_reg(8'h10, d); check("R6 one count per edge", d, 7);
    wr_reg(8'hC4, 32'h0);
    wr_reg(8'h44, 32'h6);
    wr_reg(8'h40, 32'h1);
    wr_reg(8'hC0, 32'h1);
    pulse(1, 4, 4); pulse(1, 10, 6);
    rd_reg(8'h50, d); check("R7 route 0 uses pin", d, 2);
    pulse(0, 4, 6);
    rd_reg(8'h50, d); check("R7 ch1 ignores ch0 pin", d, 2);
    wr_reg(8'hC4, 32'h4);
    pulse(1, 4, 4); pulse(1, 4, 6);
    rd_reg(8'h50, d); check("R7 route 1 selects none", d, 2);
    rd_reg(8'hC4, d); check("R7 field reads back", d, 32'h4);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    logic prev;
    int edges = 0;
    wr_reg(8'h00, 32'h2);
    wr_reg(8'hC4, 32'h8);
    wr_reg(8'h04, 32'h0009_8000);
    wr_reg(8'h14, 32'h1);
    wr_reg(8'h1C, 32'h80);
    wr_reg(8'h44, 32'h8006);
    wr_reg(8'h40, 32'h1);
    wr_reg(8'h00, 32'h1);
    wr_reg(8'hC0, 32'h1);
    prev = wave_out[0];
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (wave_out[0] && !prev) edges++;
      prev = wave_out[0];
    end
    wr_reg(8'h00, 32'h2);
    repeat (8) @(negedge clk);
    rd_reg(8'h50, d); check("R8 upper equals line edges", d, edges);
    check("R8 three passes seen", edges, 3);
    rd_reg(8'hC4, d); check("R7 chain route reads back", d, 32'h8);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr_reg(8'h04, 32'h1);
    wr_reg(8'hE4, 32'h5449_4D01);
    rd_reg(8'hE4, d); check("R10 lock on", d, 1);
    wr_reg(8'h04, 32'h1234);
    rd_reg(8'h04, d); check("R10 mode write ignored", d, 1);
    wr_reg(8'h14, 32'h77);
    rd_reg(8'h14, d); check("R10 compare still writable", d, 32'h77);
    wr_reg(8'hE4, 32'hABCD_EF00);
    rd_reg(8'hE4, d); check("R10 wrong key ignored", d, 1);
    wr_reg(8'hE4, 32'h5449_4D00);
    wr_reg(8'h04, 32'h1234);
    rd_reg(8'h04, d); check("R10 mode write after unlock", d, 32'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_irq();
    t_clock_sel();
    t_enable();
    t_trig();
    t_wrap();
    t_wave();
    t_ext();
    t_chain();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule